// File: doc/BRIEF.md
# Configurable Direct-Mapped Cache Lookup

This block is a 2-Kbyte direct-mapped cache for a core whose instruction fetches and operand accesses share one local bus. It holds 128 lines of 16 bytes. The tag array is read at the same time as a 512 x 32-bit word array, and the stored tag is compared with the upper address bits. The cache runs in one of three arrangements. It can cache only instruction fetches, or only operand reads, or it can split the arrays so that half serves instructions and half serves operands. The line index and the width of the tag compare change with the arrangement.

A read that hits returns its word in the same cycle. A read that misses raises a line request on the bus side. That request holds one line-aligned address until the whole 16-byte line comes back in a single beat. The requested word is then handed to the core, and the line is written into the arrays if the access type is cached in the current arrangement. Stores are write-through. Each store is forwarded to the bus in the cycle it is presented, and it updates the word array only when it hits. A synchronous invalidate-all input clears every valid bit. The arrangement may be changed only after an invalidate.

Top module: `cfg_dm_cache`

## Requirements
- R1: After reset no line is valid, and `ack_o`, `fill_req_o` and `wr_o` are 0 while no request is presented. The first read of any address therefore misses.
- R2: A read that hits asserts `ack_o` combinationally in the cycle it is presented, with the stored word on `rdata_o`. It does not raise `fill_req_o` in the following cycle.
- R3: In the instruction-only and data-only arrangements, the line index is address bits [10:4] and the tag compare uses bits [31:11]. Addresses that differ only in bit 10 use different lines. Addresses that share bits [10:4] but differ above bit 10 evict each other.
- R4: In the split arrangement, the index MSB is 1 for instruction fetches and 0 for operand reads, and address bits [9:4] supply the rest. The tag compare uses bits [31:10]. The same address fetched as an instruction and read as an operand occupies two lines. Same-type addresses that differ only in bit 10 evict each other.
- R5: A read miss asserts `fill_req_o` from the next cycle. `fill_addr_o` holds the address with bits [3:0] cleared, and both stay unchanged until `fill_valid_i`. In the `fill_valid_i` cycle, `ack_o` is 1 and `rdata_o` is word k = addr[3:2] of `fill_data_i`, where word k occupies bits [32k+31:32k].
- R6: `mode_i` = 00 caches only instruction reads, 01 caches only operand reads, and 1x (10 or 11) is split and caches both. Only cached types allocate on a miss. An access of a type that is not cached never hits.
- R7: A store (`req_write_i` = 1, always treated as an operand access) is acknowledged in the cycle it is presented. It drives `wr_o` = 1 with its address and data on `wr_addr_o`/`wr_data_o`, and it never raises `fill_req_o`.
- R8: A store that hits replaces the cached word, and a later read returns the new value. A store that misses allocates nothing.
- R9: `inval_i` clears all valid bits at the next edge. If it is asserted while a fill is pending, that fill still acknowledges the read but does not allocate its line.
- R10: Only one fill is outstanding. While `fill_req_o` is 1 and `fill_valid_i` is 0, there is no lookup, no `ack_o` and no `wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Arrangement: 00 instruction-only, 01 data-only, 1x split |
| inval_i | input | 1 | Invalidate all lines |
| req_valid_i | input | 1 | Access request, held until `ack_o` |
| req_instr_i | input | 1 | 1 = instruction fetch, 0 = operand (ignored for stores) |
| req_write_i | input | 1 | 1 = store |
| req_addr_i | input | 32 | Byte address (word aligned) |
| req_wdata_i | input | 32 | Store data |
| ack_o | output | 1 | Access complete this cycle |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| fill_req_o | output | 1 | Line fill request |
| fill_addr_o | output | 32 | Line-aligned fill address |
| fill_valid_i | input | 1 | Fill line returned |
| fill_data_i | input | 128 | Returned line, word k at bits [32k+31:32k] |
| wr_o | output | 1 | Store forwarded to the bus |
| wr_addr_o | output | 32 | Forwarded store address |
| wr_data_o | output | 32 | Forwarded store data |

## Verification
The hardest case to reach is an invalidate that lands while a fill is pending. To check it, the stimulus must hold a miss open over a chosen number of wait cycles, assert `inval_i` inside that window, and then show through a later read that the returned line was not kept. The bench builds each read miss as a sequence with a random fill latency, and can raise `inval_i` in the first wait cycle, both in directed calls and in a random fraction of reads. Other cases need the random stimulus to revisit addresses. Evictions, split-half separation and stale instruction lines after operand stores all depend on that, so addresses are drawn from a small pool of indices and tags to make hits and conflicts frequent in every arrangement.

// File: rtl/cfg_dm_cache.sv
module cfg_dm_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 128,
  parameter int LINE_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode_i,
  input  logic                         inval_i,
  input  logic                         req_valid_i,
  input  logic                         req_instr_i,
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [31:0]                  req_wdata_i,
  output logic                         ack_o,
  output logic [31:0]                  rdata_o,
  output logic                         fill_req_o,
  output logic [ADDR_W-1:0]            fill_addr_o,
  input  logic                         fill_valid_i,
  input  logic [LINE_BYTES*8-1:0]      fill_data_i,
  output logic                         wr_o,
  output logic [ADDR_W-1:0]            wr_addr_o,
  output logic [31:0]                  wr_data_o
);
  localparam int DW     = 32;
  localparam int WPL    = LINE_BYTES / 4;
  localparam int WOFF_W = $clog2(WPL);
  localparam int BOFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - BOFF_W - IDX_W + 1;
  localparam int DIDX_W = IDX_W + WOFF_W;
  localparam int WORDS  = LINES * WPL;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DW-1:0]     data_q [WORDS];

  logic              pend_q, drop_q, mcache_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [IDX_W-1:0]  midx_q;

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a,
                                                 input logic ins, input logic split);
    if (split) return {ins, a[BOFF_W+IDX_W-2:BOFF_W]};
    return a[BOFF_W+IDX_W-1:BOFF_W];
  endfunction

  logic              split, rd_ins, cacheable, lookup, tag_hit, hit, st, fill_done;
  logic [IDX_W-1:0]  idx;
  logic [DIDX_W-1:0] widx;
  logic [TAG_W-1:0]  req_tag, cur_tag;
  logic [DW-1:0]     fill_word;

  assign split     = mode_i[1];
  assign rd_ins    = req_instr_i & ~req_write_i;
  assign cacheable = split | (mode_i[0] ? ~rd_ins : rd_ins);
  assign idx       = line_idx(req_addr_i, rd_ins, split);
  assign widx      = {idx, req_addr_i[BOFF_W-1:2]};
  assign req_tag   = req_addr_i[ADDR_W-1:BOFF_W+IDX_W-1];
  assign cur_tag   = tag_q[idx];
  assign tag_hit   = valid_q[idx] &&
                     (split ? (cur_tag == req_tag) : (cur_tag[TAG_W-1:1] == req_tag[TAG_W-1:1]));
  assign lookup    = req_valid_i & ~pend_q;
  assign hit       = lookup & cacheable & tag_hit;
  assign st        = lookup & req_write_i;
  assign fill_done = pend_q & fill_valid_i;
  assign fill_word = fill_data_i[maddr_q[BOFF_W-1:2]*DW +: DW];

  assign ack_o       = (hit & ~req_write_i) | st | fill_done;
  assign rdata_o     = fill_done ? fill_word : data_q[widx];
  assign fill_req_o  = pend_q;
  assign fill_addr_o = {maddr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  assign wr_o        = st;
  assign wr_addr_o   = req_addr_i;
  assign wr_data_o   = req_wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      drop_q   <= 1'b0;
      mcache_q <= 1'b0;
      maddr_q  <= '0;
      midx_q   <= '0;
    end else if (pend_q) begin
      if (inval_i) drop_q <= 1'b1;
      if (fill_valid_i) pend_q <= 1'b0;
    end else if (lookup && !req_write_i && !hit) begin
      pend_q   <= 1'b1;
      drop_q   <= 1'b0;
      mcache_q <= cacheable;
      maddr_q  <= req_addr_i;
      midx_q   <= idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (inval_i) valid_q <= '0;
    else if (fill_done && mcache_q && !drop_q) valid_q[midx_q] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_done && mcache_q && !drop_q) begin
      tag_q[midx_q] <= maddr_q[ADDR_W-1:BOFF_W+IDX_W-1];
      for (int w = 0; w < WPL; w++)
        data_q[{midx_q, WOFF_W'(w)}] <= fill_data_i[w*DW +: DW];
    end else if (st && hit) begin
      data_q[widx] <= req_wdata_i;
    end
  end

  p_hit_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && ack_o && !fill_req_o) |=> !fill_req_o);

  p_miss_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && !ack_o && !fill_req_o) |=> fill_req_o);

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o)));

  p_store_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && !fill_req_o) |-> (ack_o && wr_o));

  p_store_no_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && !fill_req_o) |=> !fill_req_o);

  p_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> (valid_q == '0));

  p_one_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_o && !fill_valid_i) |-> (!ack_o && !wr_o));
endmodule

// File: tb/tb_cfg_dm_cache.sv
`timescale 1ns/1ps
module tb_cfg_dm_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic inval_i = 1'b0, req_valid_i = 1'b0, req_instr_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic ack_o, fill_req_o, wr_o, fill_valid_i = 1'b0;
  logic [31:0] rdata_o, fill_addr_o, wr_addr_o, wr_data_o;
  logic [127:0] fill_data_i = '0;

  always #2.5 clk = ~clk;

  cfg_dm_cache dut (.*);

  int vecs = 0, fails = 0;
  bit        mv [128];
  logic [21:0] mt [128];
  logic [31:0] md [512];
  logic [31:0] ov [bit [29:0]];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (ov.exists(a[31:2])) return ov[a[31:2]];
    return {a[31:2], 2'b01} ^ 32'hA5C3_0F1E;
  endfunction

  function automatic bit cach(bit ins, logic [1:0] m);
    return m[1] | (m[0] ? !ins : ins);
  endfunction

  function automatic int mi(logic [31:0] a, bit ins, logic [1:0] m);
    return m[1] ? int'({ins, a[9:4]}) : int'(a[10:4]);
  endfunction

  function automatic bit mhit(logic [31:0] a, bit ins, logic [1:0] m);
    int i = mi(a, ins, m);
    if (!cach(ins, m) || !mv[i]) return 1'b0;
    return m[1] ? (mt[i] == a[31:10]) : (mt[i][21:1] == a[31:11]);
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 128; i++) mv[i] = 1'b0;
  endtask

  task automatic rd(bit ins, logic [31:0] a, bit inval_mid, string r);
    int i, d;
    bit eh, drop;
    logic [31:0] ew;
    logic [127:0] line;
    i = mi(a, ins, mode_i);
    eh = mhit(a, ins, mode_i);
    ew = eh ? md[i*4 + int'(a[3:2])] : mem_word(a);
    drop = 1'b0;
    for (int w = 0; w < 4; w++) line[w*32 +: 32] = mem_word({a[31:4], w[1:0], 2'b00});
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_instr_i = ins; req_addr_i = a;
    #1;
    chk({r, " hit"}, 32'(ack_o), 32'(eh));
    if (eh) chk({r, " hit data"}, rdata_o, ew);
    else begin
      d = $urandom % 3;
      for (int k = 0; k <= d; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (inval_mid && k == 0) begin
          inval_i = 1'b1; clear_model(); drop = 1'b1;
        end
        if (k == d) begin fill_valid_i = 1'b1; fill_data_i = line; end
        #1;
        chk("R5 fill_req", 32'(fill_req_o), 32'd1);
        chk("R5 fill_addr", fill_addr_o, {a[31:4], 4'b0});
        if (k < d) chk("R10 no ack while pending", 32'(ack_o), 32'd0);
        else begin
          chk({r, " R5 fill ack"}, 32'(ack_o), 32'd1);
          chk({r, " R5 fill word"}, rdata_o, ew);
        end
      end
    end
    @(negedge clk);
    req_valid_i = 1'b0; fill_valid_i = 1'b0; inval_i = 1'b0;
    if (!eh && cach(ins, mode_i) && !drop) begin
      mv[i] = 1'b1; mt[i] = a[31:10];
      for (int w = 0; w < 4; w++) md[i*4 + w] = line[w*32 +: 32];
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] dat, string r);
    int i;
    bit eh;
    i = mi(a, 1'b0, mode_i);
    eh = mhit(a, 1'b0, mode_i);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_instr_i = 1'b0; req_addr_i = a; req_wdata_i = dat;
    #1;
    chk({r, " R7 store ack"}, 32'(ack_o), 32'd1);
    chk({r, " R7 wr_o"}, 32'(wr_o), 32'd1);
    chk({r, " R7 wr_addr"}, wr_addr_o, a);
    chk({r, " R7 wr_data"}, wr_data_o, dat);
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    #1;
    chk("R7 no fill after store", 32'(fill_req_o), 32'd0);
    if (eh) md[i*4 + int'(a[3:2])] = dat;
    ov[a[31:2]] = dat;
  endtask

  task automatic inval_all();
    @(negedge clk); inval_i = 1'b1;
    @(negedge clk); inval_i = 1'b0;
    clear_model();
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); mode_i = m; inval_i = 1'b1;
    @(negedge clk); inval_i = 1'b0;
    clear_model();
  endtask

  function automatic logic [31:0] rnd_addr();
    logic [31:0] r = $urandom;
    return {r[0], 19'd0, r[1], r[2], 3'b000, r[5:3], r[7:6], 2'b00};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] A, B;
    void'($urandom(32'd2024));
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 ack after reset", 32'(ack_o), 32'd0);
    chk("R1 fill_req after reset", 32'(fill_req_o), 32'd0);
    chk("R1 wr after reset", 32'(wr_o), 32'd0);

    A = 32'h0000_0124;
    set_mode(2'b00);
    rd(1'b1, A, 1'b0, "R1 first miss");
    rd(1'b1, A, 1'b0, "R2");
    rd(1'b1, A ^ 32'h400, 1'b0, "R3 bit10 other line");
    rd(1'b1, A, 1'b0, "R3 still hit");
    rd(1'b1, A ^ 32'h800, 1'b0, "R3 conflict");
    rd(1'b1, A, 1'b0, "R3 evicted");
    rd(1'b0, A, 1'b0, "R6 operand uncached");
    rd(1'b0, A, 1'b0, "R6 operand never hits");
    wr(A, 32'hDEAD_0001, "R6 store uncached");
    rd(1'b1, A, 1'b0, "R6 instr copy stale");

    B = 32'h8000_0230;
    set_mode(2'b01);
    rd(1'b1, B, 1'b0, "R6 instr uncached");
    rd(1'b1, B, 1'b0, "R6 instr never hits");
    rd(1'b0, B, 1'b0, "R6 operand alloc");
    wr(B + 4, 32'h1234_5678, "R8 store hit");
    rd(1'b0, B + 4, 1'b0, "R8 updated word");
    wr(32'h0000_0F00, 32'hCAFE_F00D, "R8 store miss");
    rd(1'b0, 32'h0000_0F00, 1'b0, "R8 no alloc");

    set_mode(2'b10);
    rd(1'b1, A, 1'b0, "R4 instr half");
    rd(1'b0, A, 1'b0, "R4 operand half");
    rd(1'b1, A, 1'b0, "R4 instr hit");
    rd(1'b0, A, 1'b0, "R4 operand hit");
    rd(1'b1, A ^ 32'h400, 1'b0, "R4 bit10 conflict");
    rd(1'b1, A, 1'b0, "R4 evicted");
    rd(1'b0, A, 1'b0, "R4 operand kept");
    rd(1'b0, B, 1'b1, "R9 inval mid fill");
    rd(1'b0, B, 1'b0, "R9 dropped line");
    inval_all();
    rd(1'b0, B, 1'b0, "R9 after inval");

    for (int m = 0; m < 4; m++) begin
      set_mode(m[1:0]);
      for (int n = 0; n < 400; n++) begin
        logic [31:0] r = $urandom;
        if (r[3:0] < 4) wr(rnd_addr(), $urandom, "R8 random");
        else rd(r[4], rnd_addr(), r[9:5] == 0, "R2 random");
      end
    end
    summary();
  end
endmodule